// File: doc/BRIEF.md
# Serial EEPROM Target for a Two-Wire Bus

This block is a two-wire bus target (SMBus / I2C) that holds a 256-byte EEPROM image and serves it to a bus master. It watches SCL and SDA as plain inputs. It pulls SDA low through an output enable, which the chip turns into an open-drain pad. Several copies can share one bus: each copy answers at the 7-bit address `BASE_ADDR + dev_sel`, where `dev_sel` is a strap from 0 to 7.

A write transaction works in two parts. The first data byte after the address is the new value of the internal 8-bit byte pointer. Every later byte is stored at the pointer, and the pointer then advances. A read transaction has no command phase: it streams bytes from wherever the pointer stands, and the pointer advances after each byte. The pointer wraps from 255 to 0 and keeps its value across transactions. A separate parallel port lets the chip preload the storage array before or between bus traffic.

The controller is one state machine with these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WR_BYTE`, `ST_WR_ACK`, `ST_RD_BYTE` and `ST_RD_ACK`.

Its transitions are:
- A START in any state goes to `ST_ADDR`.
- A STOP in any state goes to `ST_IDLE`.
- In `ST_ADDR`, after eight bits, a matching address goes to `ST_ADDR_ACK`. A foreign address goes to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` for a read and to `ST_WR_BYTE` for a write.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits.
- `ST_WR_ACK` goes back to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_BYTE` when the master ACKs, and to `ST_IDLE` when the master NACKs.

Top module: `smbus_eeprom_target`

## Requirements
- R1: The block drives an ACK (SDA low during the ninth clock) for an address byte whose upper seven bits equal `BASE_ADDR + dev_sel`. It also ACKs every byte written to it.
- R2: For any other address, `sda_oe` stays 0 from the START until the next START or STOP.
- R3: In a write transaction, the first byte after the address replaces the pointer and stores nothing.
- R4: Every later write byte is stored at the pointer, and the pointer then advances by one, wrapping from 255 to 0.
- R5: A read sends bytes MSB first. Each byte comes from the current pointer, and the pointer then advances by one, wrapping from 255 to 0.
- R6: A read has no command phase. It starts at the pointer left by the previous transaction, including the value left when a write ends.
- R7: A master NACK after a read byte ends the read, and the pointer keeps its advanced value.
- R8: A repeated START begins a new transaction, and the pointer is kept across it.
- R9: The pointer is 0 after reset.
- R10: A pulse on `init_we` writes `init_data` to byte `init_addr` of the array. That byte is then returned by bus reads.
- R11: SDA is released (`sda_oe` = 0) after reset and after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_sel | input | 3 | Instance index added to the base address |
| init_we | input | 1 | Preload write strobe |
| init_addr | input | 8 | Preload byte address |
| init_data | input | 8 | Preload byte value |

## Verification
A pin change reaches the state machine three clocks after it happens: two synchroniser flops, then the edge compare. `sda_oe` follows the state register in the same cycle. The bench therefore holds every SCL phase for six clocks. It reads SDA (ACK bits and read data) at the end of the SCL-high phase, which is at least nine clocks after the falling edge where the target updates SDA. Stored bytes and pointer moves are not visible at the pins, so the bench checks them later, through read transactions, against its own model of the array and the pointer.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          init_we,
    input  logic [AW-1:0] init_addr,
    input  logic [DW-1:0] init_data,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (init_we) begin
            cells[init_addr] <= init_data;
        end else if (bus_we) begin
            cells[bus_addr] <= bus_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/smbus_eeprom_target.sv
module smbus_eeprom_target
    import smbus_eeprom_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR   = 7'h50,
    parameter int         SEL_W       = 3,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic             init_we,
    input  logic [PTR_W-1:0] init_addr,
    input  logic [7:0]       init_data
);
    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

    tgt_state_t        state;
    logic [7:0]        shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [PTR_W-1:0]  ptr;
    logic              first;
    logic              rw;
    logic              mack;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]        own_addr;
    logic [7:0]        rd_data;
    logic              mem_we;
    logic              ptr_load;
    logic              rd_load;
    logic              byte_done;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    eeprom_array #(.AW(PTR_W), .DW(8)) u_array (
        .clk      (clk),
        .init_we  (init_we),
        .init_addr(init_addr),
        .init_data(init_data),
        .bus_we   (mem_we),
        .bus_addr (ptr),
        .bus_data (shreg),
        .rd_addr  (ptr),
        .rd_data  (rd_data)
    );

    assign own_addr  = BASE_ADDR + 7'(dev_sel);
    assign byte_done = scl_fall && (bitcnt == FULL_CNT);
    assign mem_we    = (state == ST_WR_BYTE) && byte_done && !first;
    assign ptr_load  = (state == ST_WR_BYTE) && byte_done && first;
    assign rd_load   = scl_fall && (((state == ST_ADDR_ACK) && rw) ||
                                    ((state == ST_RD_ACK) && mack));

    // State register together with the shift and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            ptr    <= '0;
            first  <= 1'b0;
            rw     <= 1'b0;
            mack   <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            first  <= 1'b1;
        end else if (stop_det) begin
            state  <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        if (shreg[7:1] == own_addr) begin
                            state <= ST_ADDR_ACK;
                            rw    <= shreg[0];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            state <= ST_RD_BYTE;
                            shreg <= rd_data;
                            ptr   <= ptr + PTR_W'(1);
                        end else begin
                            state <= ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        state <= ST_WR_ACK;
                        first <= 1'b0;
                        if (first) begin
                            ptr <= PTR_W'(shreg);
                        end else begin
                            ptr <= ptr + PTR_W'(1);
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state  <= ST_WR_BYTE;
                        bitcnt <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b1};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_CNT) begin
                            state <= ST_RD_ACK;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            state  <= ST_RD_BYTE;
                            shreg  <= rd_data;
                            ptr    <= ptr + PTR_W'(1);
                            bitcnt <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode: SDA pull-down
    always_comb begin
        unique case (state)
            ST_ADDR_ACK,
            ST_WR_ACK:   sda_oe = 1'b1;
            ST_RD_BYTE:  sda_oe = ~shreg[7];
            default:     sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/smbus_eeprom_chk.sv
module smbus_eeprom_chk
    import smbus_eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       stop_det,
    input tgt_state_t state,
    input logic [7:0] ptr,
    input logic [7:0] shreg,
    input logic [6:0] own_addr,
    input logic       mem_we,
    input logic       ptr_load,
    input logic       rd_load
);
    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[7:1] == own_addr)); // R1

    AST_NO_FOREIGN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state != ST_IDLE && state != ST_ADDR)); // R2

    AST_PTR_FROM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (ptr == $past(shreg))); // R3

    AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr == $past(ptr) + 8'd1)); // R4

    AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (ptr == $past(ptr) + 8'd1)); // R5

    AST_PTR_RESET: assert property (@(posedge clk)
        !rst_n |-> (ptr == 8'd0)); // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R11
endmodule

bind smbus_eeprom_target smbus_eeprom_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .stop_det(stop_det),
    .state   (state),
    .ptr     (ptr),
    .shreg   (shreg),
    .own_addr(own_addr),
    .mem_we  (mem_we),
    .ptr_load(ptr_load),
    .rd_load (rd_load)
);

// File: tb/sim_smbus_eeprom_target.sv
module sim_smbus_eeprom_target;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [2:0] dev_sel = 3'd5;
    logic       init_we = 1'b0;
    logic [7:0] init_addr = '0;
    logic [7:0] init_data = '0;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    bit   watch_oe = 0;
    bit   saw_oe = 0;

    logic [7:0] model [256];
    logic [7:0] mptr;

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    smbus_eeprom_target u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .dev_sel  (dev_sel),
        .init_we  (init_we),
        .init_addr(init_addr),
        .init_data(init_data)
    );

    always @(negedge clk) if (watch_oe && sda_oe) saw_oe = 1;

    function automatic logic [7:0] step(input logic [7:0] p);
        return p + 8'd1;
    endfunction

    function automatic logic [6:0] own();
        return 7'h50 + 7'(dev_sel);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        m_low = 0; wq(); m_scl = 1; wq(); m_low = 1; wq(); m_scl = 0; wq();
    endtask

    task automatic bstop();
        m_low = 1; wq(); m_scl = 1; wq(); m_low = 0; wq();
    endtask

    task automatic put_bit(input bit b);
        m_low = ~b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq();
    endtask

    task automatic get_bit(output bit b);
        m_low = 0; wq(); m_scl = 1; wq(); b = sda_line; wq(); m_scl = 0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(s);
        ack = ~s;
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin get_bit(s); v[i] = s; end
        put_bit(~give_ack);
        m_low = 0;
    endtask

    // write transaction: first byte = pointer, then data
    task automatic do_write(input logic [7:0] p, input int n, input bit stop);
        bit ack;
        logic [7:0] d;
        put_byte({own(), 1'b0}, ack);
        chk(ack, "R1 addr ack (write)", ack, 1);
        put_byte(p, ack);
        chk(ack, "R1 pointer byte ack", ack, 1);
        mptr = p;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            put_byte(d, ack);
            chk(ack, "R1 data byte ack", ack, 1);
            model[mptr] = d;
            mptr = step(mptr);
        end
        if (stop) bstop();
    endtask

    task automatic do_read(input int n, input bit stop, input string req);
        bit ack;
        logic [7:0] v;
        put_byte({own(), 1'b1}, ack);
        chk(ack, "R1 addr ack (read)", ack, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, v);
            chk(v === model[mptr], req, v, model[mptr]);
            mptr = step(mptr);
        end
        if (stop) bstop();
    endtask

    task automatic foreign(input logic [6:0] a, input bit rd);
        bit ack;
        logic [7:0] v;
        saw_oe = 0; watch_oe = 1;
        put_byte({a, rd}, ack);
        if (rd) get_byte(1'b0, v);
        else put_byte(8'($urandom), ack);
        watch_oe = 0;
        chk(!saw_oe, "R2 foreign address left SDA alone", saw_oe, 0);
        bstop();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // preload during reset
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            init_we = 1; init_addr = 8'(i); init_data = 8'($urandom);
            model[i] = init_data;
        end
        @(negedge clk); init_we = 0;
        mptr = 8'd0;
        chk(sda_oe == 0, "R11 sda released in reset", sda_oe, 0);
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk(sda_oe == 0, "R11 sda released after reset", sda_oe, 0);

        // R9 + R10: first read after reset starts at byte 0 of the preload
        bstart(); do_read(3, 1, "R9 R10 read from reset pointer");

        // R3 R4 wrap write across 255 -> 0
        bstart(); do_write(8'hFE, 4, 1);
        // R6: read continues at pointer left by write (0x02)
        bstart(); do_read(2, 1, "R6 read with no command phase");
        // R3: pointer-only write stores nothing, then read from it
        bstart(); do_write(8'hFF, 0, 1);
        bstart(); do_read(3, 1, "R5 read wraps 255 to 0");
        // R7: NACK-terminated read, next read continues
        bstart(); do_read(1, 1, "R7 pointer kept after NACK");
        bstart(); do_read(2, 1, "R7 continued read");
        // R8: repeated start from write into read
        bstart(); do_write(8'h40, 2, 0);
        bstart(); do_read(3, 1, "R8 read after repeated START");
        // R10: preload between transactions
        @(negedge clk); init_we = 1; init_addr = 8'h80; init_data = 8'hA5; model[8'h80] = 8'hA5;
        @(negedge clk); init_we = 0;
        bstart(); do_write(8'h80, 0, 1);
        bstart(); do_read(1, 1, "R10 preload seen on bus");
        // R2: other instance and random foreign address
        bstart(); foreign(7'h50, 1'b0);
        bstart(); foreign(7'h50, 1'b1);
        bstart(); do_read(1, 1, "R2 pointer untouched by foreign traffic");
        chk(sda_oe == 0, "R11 sda released after stop", sda_oe, 0);

        // constrained random traffic
        for (int t = 0; t < 30; t++) begin
            int kind = int'($urandom_range(0, 5));
            bstart();
            if (kind < 2) do_write(8'($urandom), int'($urandom_range(0, 4)), kind == 0);
            else if (kind < 5) do_read(int'($urandom_range(1, 4)), kind != 4, "R5 random read");
            else begin
                logic [6:0] a;
                a = 7'($urandom);
                if (a == own()) a = a ^ 7'h01;
                foreign(a, 1'($urandom));
            end
        end
        bstart(); do_read(2, 1, "R4 R5 final readback");
        chk(sda_oe == 0, "R11 idle after traffic", sda_oe, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule